// File: doc/BRIEF.md
# Per-Pin GPIO Port Pad Controller

This block controls a parameterised general-purpose I/O port. Each pin has its own slice holding an output data bit, a direction bit and an open-drain bit. Port-wide bits turn the internal pull on, choose its polarity, and keep the drivers on while the chip is in power-down. From these the block produces abstract pad controls for every pin: output value, output enable, pull-up enable and pull-down enable. The analog pad and the peripherals are outside the block.

A peripheral can take over a pin through an alternate-function enable. While that enable is high, the peripheral supplies both the output value and the direction, in place of the port's data and direction bits. The pad input is sampled into an input register on every clock, and a read of the data address returns that sampled value. Software reaches the registers one at a time by address, with single-cycle write strobes and combinational read data.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every data, direction, open-drain, pull-enable, pull-select, hold and input-register bit. After reset no pin drives, and no pull is on.
- R2: A pin's effective direction is `alt_dir[i]` when `alt_en[i]` is 1 and the direction bit otherwise (1 = output, 0 = input). Only a pin whose effective direction is output can have `pad_oe[i]` high.
- R3: When a pin's open-drain bit is 1, `pad_out[i]` is 0 and `pad_oe[i]` is high only while the selected output value is 0. When the bit is 0, an output pin drives the selected value push-pull.
- R4: For a pin whose effective direction is input, `pad_pu[i]` equals pull-enable AND pull-select, and `pad_pd[i]` equals pull-enable AND NOT pull-select (pull-select 1 = pull-up). This holds whatever the state of `pwr_down`.
- R5: For a pin whose effective direction is output, `pad_pu[i]` and `pad_pd[i]` are both 0, whatever the pull bits say.
- R6: While `pwr_down` is 1 and the hold bit is 0, every `pad_oe` bit is 0. When the hold bit is 1, the drivers behave as in normal operation.
- R7: The selected output value is `alt_out[i]` when `alt_en[i]` is 1 and the data bit otherwise. In push-pull mode `pad_out[i]` equals the selected value.
- R8: The data address (0) reads the value of `pad_in` captured at the previous rising clock edge, not the data bits.
- R9: Writes take effect at the clock edge of the strobe. The addresses are 1 direction, 2 open-drain, 3 pull-enable, 4 pull-select and 5 hold; a write to address 0 sets the data bits. The port-wide bits use bit 0 of the write data and read back in bit 0, with zeros above. Addresses 6 and 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for `reg_addr` (combinational) |
| alt_en | input | NPINS | Per-pin alternate-function enable |
| alt_dir | input | NPINS | Alternate-function direction (1 = output) |
| alt_out | input | NPINS | Alternate-function output value |
| pwr_down | input | 1 | Power-down indication |
| pad_in | input | NPINS | Pad input values |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output-driver enable |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |

## Verification
Two events can fall in the same cycle. A register write can change a pin's direction or the pull bits in the very cycle that `pwr_down` or `alt_en` toggles, so the power-down gating, the alternate takeover and the new register value all meet in one evaluation. A pad change can also coincide with a read of the data address. The bench provokes both cases with an exhaustive sweep of direction, open-drain, pull-enable, pull-select, power-down and hold, followed by a random phase in which writes, power-down, alternate controls and pad values change together. A reference model holds each register write until the next rising edge and captures the pad at that same edge. Every pad control and the read data are compared against it in every cycle.

// File: rtl/gpio_pkg.sv
// Shared constants for the GPIO pad controller: the register address map.
// Assumes a 3-bit register address; addresses 6 and 7 are unused.
package gpio_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] A_ODRN = 3'd2;
    localparam logic [ADDR_W-1:0] A_PEN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PSEL = 3'd4;
    localparam logic [ADDR_W-1:0] A_HOLD = 3'd5;
endpackage

// File: rtl/gpio_in_latch.sv
// Input capture register: samples the pad inputs on every rising clock edge.
// Assumes pad_in is already synchronous to clk, or is tolerated as such.
module gpio_in_latch #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] in_q
);
    // Capture the pad values; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= pad_in;
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Register file of the port: per-pin data, direction and open-drain bits, and
// the port-wide pull-enable, pull-select and hold bits. Writes happen one at a
// time by address. Reads are combinational; the data address returns the
// captured pad inputs. Port-wide bits use bit 0 of the data bus.
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  in_q,
    output logic [NPINS-1:0]  dat_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  od_q,
    output logic              pen_q,
    output logic              psel_q,
    output logic              hold_q,
    output logic [NPINS-1:0]  rdata
);
    localparam int HI_W = NPINS - 1;

    // Per-pin registers: load the addressed register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
            od_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_DATA) dat_q <= wdata;
            if (addr == A_DIR)  dir_q <= wdata;
            if (addr == A_ODRN) od_q  <= wdata;
        end
    end

    // Port-wide single-bit registers, taken from bit 0 of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q  <= 1'b0;
            psel_q <= 1'b0;
            hold_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_PEN)  pen_q  <= wdata[0];
            if (addr == A_PSEL) psel_q <= wdata[0];
            if (addr == A_HOLD) hold_q <= wdata[0];
        end
    end

    // Read multiplexer; unused addresses return zero.
    always_comb begin
        unique case (addr)
            A_DATA:  rdata = in_q;
            A_DIR:   rdata = dir_q;
            A_ODRN:  rdata = od_q;
            A_PEN:   rdata = {{HI_W{1'b0}}, pen_q};
            A_PSEL:  rdata = {{HI_W{1'b0}}, psel_q};
            A_HOLD:  rdata = {{HI_W{1'b0}}, hold_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_slice.sv
// Pad control for one pin. It chooses between the port and the alternate
// function for both the output value and the direction, applies open-drain
// and power-down gating, and enables a pull only on input pins.
// Purely combinational.
module gpio_pin_slice (
    input  logic dat,
    input  logic dir,
    input  logic od,
    input  logic alt_en,
    input  logic alt_dir,
    input  logic alt_out,
    input  logic pen,
    input  logic psel,
    input  logic drive_ok,
    output logic out,
    output logic oe,
    output logic pu,
    output logic pd
);
    logic eff_dir;
    logic sel_val;

    // Source selection: the alternate function overrides value and direction.
    always_comb begin
        eff_dir = alt_en ? alt_dir : dir;
        sel_val = alt_en ? alt_out : dat;
    end

    // Driver: open-drain drives low only; power-down gating applies.
    always_comb begin
        out = od ? 1'b0 : sel_val;
        oe  = eff_dir & drive_ok & ~(od & sel_val);
    end

    // Pull: only on input pins, polarity from the select bit.
    always_comb begin
        pu = ~eff_dir & pen & psel;
        pd = ~eff_dir & pen & ~psel;
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Top of the GPIO pad controller: the register file, the input capture
// register and one pin slice per pin. Assumes a single clock domain and
// a synchronous active-low reset.
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  alt_en,
    input  logic [NPINS-1:0]  alt_dir,
    input  logic [NPINS-1:0]  alt_out,
    input  logic              pwr_down,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd
);
    logic [NPINS-1:0] in_q, dat_q, dir_q, od_q;
    logic             pen_q, psel_q, hold_q;
    logic             drive_ok;

    gpio_in_latch #(.NPINS(NPINS)) u_in (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .in_q(in_q)
    );

    gpio_port_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .in_q(in_q), .dat_q(dat_q), .dir_q(dir_q),
        .od_q(od_q), .pen_q(pen_q), .psel_q(psel_q), .hold_q(hold_q),
        .rdata(reg_rdata)
    );

    // Drivers are allowed outside power-down, or when the hold bit is set.
    always_comb drive_ok = ~pwr_down | hold_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_slice u_slice (
            .dat(dat_q[i]), .dir(dir_q[i]), .od(od_q[i]),
            .alt_en(alt_en[i]), .alt_dir(alt_dir[i]), .alt_out(alt_out[i]),
            .pen(pen_q), .psel(psel_q), .drive_ok(drive_ok),
            .out(pad_out[i]), .oe(pad_oe[i]), .pu(pad_pu[i]), .pd(pad_pd[i])
        );
    end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
// Assertion checker for gpio_pad_ctrl, attached with bind. It relates the
// pad controls to the register state and the ports over time.
module gpio_pad_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPINS-1:0]  reg_wdata,
    input logic [NPINS-1:0]  reg_rdata,
    input logic [NPINS-1:0]  alt_en,
    input logic [NPINS-1:0]  alt_out,
    input logic              pwr_down,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd,
    input logic [NPINS-1:0]  dat_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  od_q,
    input logic              hold_q
);
    AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);                                          // R4
    AST_OUT_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pu | pad_pd)) == '0);                               // R5
    AST_PDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !hold_q) |-> (pad_oe == '0));                         // R6
    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (od_q & pad_oe & ((alt_en & alt_out) | (~alt_en & dat_q))) == '0); // R3
    AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_addr == A_DATA) |-> (reg_rdata == $past(pad_in))); // R8
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIR) |=> (dir_q == $past(reg_wdata)));    // R9
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_en(alt_en),
    .alt_out(alt_out), .pwr_down(pwr_down), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .dat_q(dat_q), .dir_q(dir_q),
    .od_q(od_q), .hold_q(hold_q)
);

// File: tb/sim_gpio_pad_ctrl.sv
// Self-checking bench: a behavioural reference model compared on every clock.
module sim_gpio_pad_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] alt_en = '0, alt_dir = '0, alt_out = '0;
    logic         pwr_down = 1'b0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [N-1:0] m_dat = '0, m_dir = '0, m_od = '0, m_in = '0;
    logic         m_pen = 1'b0, m_psel = 1'b0, m_hold = 1'b0;

    always #2 clk = ~clk;

    gpio_pad_ctrl #(.NPINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_en(alt_en),
        .alt_dir(alt_dir), .alt_out(alt_out), .pwr_down(pwr_down),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Compare every output against the model for the current inputs.
    task automatic compare(input string rtag);
        logic [N-1:0] e_out, e_oe, e_pu, e_pd, e_rd;
        for (int i = 0; i < N; i++) begin
            bit de, sv, drv;
            de  = alt_en[i] ? alt_dir[i] : m_dir[i];
            sv  = alt_en[i] ? alt_out[i] : m_dat[i];
            drv = !pwr_down || m_hold;
            e_oe[i]  = de && drv && !(m_od[i] && sv);
            e_out[i] = m_od[i] ? 1'b0 : sv;
            e_pu[i]  = !de && m_pen && m_psel;
            e_pd[i]  = !de && m_pen && !m_psel;
        end
        case (reg_addr)
            3'd0: e_rd = m_in;
            3'd1: e_rd = m_dir;
            3'd2: e_rd = m_od;
            3'd3: e_rd = {{(N-1){1'b0}}, m_pen};
            3'd4: e_rd = {{(N-1){1'b0}}, m_psel};
            3'd5: e_rd = {{(N-1){1'b0}}, m_hold};
            default: e_rd = '0;
        endcase
        chk({rtag, " R2/R3/R6 pad_oe"}, pad_oe, e_oe);
        chk({rtag, " R3/R7 pad_out"}, pad_out, e_out);
        chk({rtag, " R4/R5 pad_pu"}, pad_pu, e_pu);
        chk({rtag, " R4/R5 pad_pd"}, pad_pd, e_pd);
        chk({rtag, " R8/R9 reg_rdata"}, reg_rdata, e_rd);
    endtask

    // One cycle: compare mid-cycle, advance the model at the edge, return at negedge.
    task automatic cyc(input string rtag);
        #1 compare(rtag);
        @(posedge clk);
        if (!rst_n) begin
            m_dat = '0; m_dir = '0; m_od = '0; m_in = '0;
            m_pen = 0; m_psel = 0; m_hold = 0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_dat = reg_wdata;
                    3'd1: m_dir = reg_wdata;
                    3'd2: m_od = reg_wdata;
                    3'd3: m_pen = reg_wdata[0];
                    3'd4: m_psel = reg_wdata[0];
                    3'd5: m_hold = reg_wdata[0];
                    default: ;
                endcase
            end
            m_in = pad_in;
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc("R9 write");
        reg_wr = 1'b0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        cyc("R1 reset");
        rst_n = 1'b1;
        // Reset state: all readbacks zero, nothing driven, no pull.
        for (int a = 0; a < 8; a++) begin
            reg_addr = a[2:0];
            pad_in = 8'hFF;
            cyc("R1 after-reset");
        end
        // Exhaustive sweep of direction, open-drain, pull-en, pull-sel, power-down, hold.
        for (int c = 0; c < 128; c++) begin
            wr(3'd1, c[0] ? 8'hFF : 8'h00);
            wr(3'd2, c[1] ? 8'hFF : 8'h00);
            wr(3'd3, {7'd0, c[2]});
            wr(3'd4, {7'd0, c[3]});
            wr(3'd5, {7'd0, c[5]});
            wr(3'd0, 8'hC3);
            pwr_down = c[4];
            alt_en = c[6] ? 8'h0F : 8'h00;
            alt_dir = 8'h05; alt_out = 8'h0A;
            pad_in = c[7:0] ^ 8'h96;
            reg_addr = 3'd0;
            cyc("R4/R6 sweep");
            reg_addr = 3'd1;
            cyc("R2 sweep");
        end
        // Random phase: writes, power-down, alternate takeover and pad changes collide.
        for (int k = 0; k < 3000; k++) begin
            reg_wr    = $urandom_range(0, 1);
            reg_addr  = 3'($urandom_range(0, 7));
            reg_wdata = 8'($urandom);
            alt_en    = 8'($urandom);
            alt_dir   = 8'($urandom);
            alt_out   = 8'($urandom);
            pwr_down  = ($urandom_range(0, 3) == 0);
            pad_in    = 8'($urandom);
            cyc("R7 random");
        end
        reg_wr = 1'b0;
        // Mid-run reset returns all to the reset state.
        rst_n = 1'b0;
        cyc("R1 mid-reset");
        rst_n = 1'b1; alt_en = '0; pwr_down = 1'b0; reg_addr = 3'd3;
        cyc("R1 post-reset");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule